// File: doc/BRIEF.md
# Video-Mode Line and Frame Timing Sequencer

This block paces the video stream of a serial display link host. It runs on the link byte clock and counts every interval in byte-clock cycles. Each line begins with a sync start. A horizontal sync interval and a back-porch interval follow. The line then carries either pixel packets or a blanking packet, and a front-porch interval runs until the configured line time ends. Lines are grouped into four vertical regions, visited in this order: sync, back porch, active, front porch. After the front porch the next frame begins.

In active lines the payload can be split into several chunks. In the non-burst modes each chunk may be followed by a null packet, which keeps the link busy at a steady rate. In burst mode the whole line goes out as one packet with no nulls. For every interval where the link is idle, a separate enable decides whether the downstream packetizer may drop the lanes to low power. The sequencer only emits region codes and one-cycle event strobes. Pixel data, serialization, checksums and the physical layer belong to other blocks.

All configuration comes in as register-shaped words. The block copies them into a shadow set when a frame starts, so a reprogram during a frame never corrupts that frame.

Top module: `dsi_vid_timing`

## Requirements
- R1: While `rst_ni` is low or `run_i` is low, every strobe and `lp_allowed_o` is 0 and `vregion_o` is 0. After `run_i` rises, the first line starts one cycle after the clock edge that samples it high.
- R2: Every line lasts `line_time_i` cycles, where a value of 0 counts as 1. `sync_start_o` pulses in the first cycle of each line. `frame_start_o` pulses together with it on the first line of each frame.
- R3: `vregion_o` encodes sync=0, back porch=1, active=2 and front porch=3, and the regions follow that order. Their line counts come from `vblk_i[29:20]`, `vblk_i[19:10]`, `vact_i` and `vblk_i[9:0]`. A region with zero lines is skipped. If all four are zero, each frame is a single sync line.
- R4: `mode_cfg_i[1:0]` selects the mode: 0 is non-burst with sync pulses, 1 is non-burst with sync events, and 2 or 3 is burst. In the pulse modes (0, 2 and 3), `sync_end_o` pulses at line offset `hblk_i[31:16]`. In mode 1 it never pulses.
- R5: In active lines the packet window opens at offset S = `hblk_i[31:16]` + `hblk_i[15:0]`. A pixel packet occupies `pkt_cfg_i[15:0]` + 6 cycles. `pkt_cfg_i[31:16]` gives the number of chunks, where 0 counts as 1. Chunks follow one another back to back. `pixel_pkt_o` pulses at the first cycle of each chunk.
- R6: In the non-burst modes, when `null_size_i` is not zero, each chunk is followed by a null packet of `null_size_i` + 6 cycles. `null_pkt_o` pulses at its first cycle.
- R7: In burst mode exactly one pixel packet is sent per active line and no null packets are sent, whatever the chunk count and null size say.
- R8: In lines outside the active region, `blank_o` pulses at offset S. Neither `pixel_pkt_o` nor `null_pkt_o` pulses in those lines.
- R9: `lp_allowed_o` is 0 during horizontal sync (offset below `hblk_i[31:16]`) and inside the packet window. In other lines it equals the region enable elsewhere in the line: bit 8 for sync, 9 for back porch, 10 for front porch. In active lines, the back-porch interval uses bit 12 AND bit 11 of `mode_cfg_i`, and the interval after the window uses bit 13 AND bit 11.
- R10: A packet window that would run past the end of the line is cut off at the line end, and no packet event carries over into the next line.
- R11: Configuration inputs are sampled only when a frame starts. Changes made during a frame first show in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run enable; low holds the sequencer idle |
| hblk_i | input | 32 | Horizontal sync time [31:16], back-porch time [15:0] |
| line_time_i | input | 16 | Total line time in byte clocks |
| vblk_i | input | 30 | Vertical sync [29:20], back porch [19:10], front porch [9:0] lines |
| vact_i | input | 16 | Active line count |
| mode_cfg_i | input | 14 | Low-power enables [13:8], mode [1:0] |
| pkt_cfg_i | input | 32 | Chunks per line [31:16], packet size [15:0] |
| null_size_i | input | 10 | Null packet payload size |
| vregion_o | output | 2 | Current vertical region |
| frame_start_o | output | 1 | First cycle of a frame |
| sync_start_o | output | 1 | First cycle of a line |
| sync_end_o | output | 1 | End of horizontal sync (pulse modes) |
| pixel_pkt_o | output | 1 | Start of a pixel packet |
| null_pkt_o | output | 1 | Start of a null packet |
| blank_o | output | 1 | Start of a blanking packet |
| lp_allowed_o | output | 1 | Link may idle in low power |

## Verification
The bench goes after chunk and null placement across several chunk counts. A slot-length error would shift every later pixel pulse, and a dropped null would make the chunks bunch together. It checks that burst mode ignores chunk and null settings; getting this wrong shows up as extra pixel or null pulses. Zero-length vertical regions must be skipped; getting this wrong shows up as a stuck or wrong `vregion_o`. Windows longer than the line must be cut off; getting this wrong leaks events into the next line's sync interval. Finally, a mid-frame reprogram must take effect only in the next frame; getting this wrong alters the current frame's line length.

// File: rtl/vt_pkg.sv
package vt_pkg;
  localparam int HW        = 16;  // horizontal count and packet fields
  localparam int VW        = 10;  // vertical blanking fields
  localparam int AW        = 16;  // active line count
  localparam int NW        = 10;  // null packet size
  localparam int HDR_BYTES = 6;   // per-packet overhead in byte clocks

  localparam logic [1:0] VR_SYNC  = 2'd0;
  localparam logic [1:0] VR_BACK  = 2'd1;
  localparam logic [1:0] VR_ACT   = 2'd2;
  localparam logic [1:0] VR_FRONT = 2'd3;

  localparam logic [1:0] MODE_EVENTS = 2'b01;

  typedef struct packed {
    logic [HW-1:0] hsa;
    logic [HW-1:0] hbp;
    logic [HW-1:0] line;
    logic [VW-1:0] vsa;
    logic [VW-1:0] vbp;
    logic [VW-1:0] vfp;
    logic [AW-1:0] vact;
    logic [1:0]    mode;
    logic [5:0]    lp_en;  // 0 vsync,1 vbp,2 vfp,3 vact,4 hbp,5 hfp
    logic [HW-1:0] pkt;
    logic [HW-1:0] chunks;
    logic [NW-1:0] nul;
  } vt_cfg_t;

  function automatic logic [AW-1:0] reg_len(vt_cfg_t c, logic [1:0] r);
    case (r)
      VR_SYNC: return AW'(c.vsa);
      VR_BACK: return AW'(c.vbp);
      VR_ACT:  return c.vact;
      default: return AW'(c.vfp);
    endcase
  endfunction

  // first region at or after 'from' with nonzero length, 4 when none
  function automatic logic [2:0] first_region(vt_cfg_t c, logic [2:0] from);
    logic [2:0] res;
    res = 3'd4;
    for (int i = 3; i >= 0; i--)
      if (3'(i) >= from && reg_len(c, 2'(i)) != '0) res = 3'(i);
    return res;
  endfunction
endpackage

// File: rtl/vt_hline.sv
module vt_hline
  import vt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic [HW-1:0] hsa_i,
  input  logic [HW-1:0] hbp_i,
  input  logic [HW-1:0] line_i,
  output logic [HW-1:0] hcnt_o,
  output logic          line_end_o,
  output logic          hs_o,
  output logic          hb_o,
  output logic          act_pt_o,
  output logic          hsa_pt_o
);
  logic [HW:0]   act_at;
  logic [HW-1:0] last;

  assign act_at     = {1'b0, hsa_i} + {1'b0, hbp_i};
  assign last       = (line_i == '0) ? '0 : line_i - 1'b1;
  assign line_end_o = (hcnt_o == last);
  assign hs_o       = (hcnt_o < hsa_i);
  assign hb_o       = !hs_o && ({1'b0, hcnt_o} < act_at);
  assign act_pt_o   = ({1'b0, hcnt_o} == act_at);
  assign hsa_pt_o   = (hcnt_o == hsa_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hcnt_o <= '0;
    else if (clr_i)      hcnt_o <= '0;
    else if (adv_i)      hcnt_o <= line_end_o ? '0 : hcnt_o + 1'b1;
  end
endmodule

// File: rtl/vt_chunk.sv
module vt_chunk
  import vt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          start_i,
  input  logic          line_end_i,
  input  logic          burst_i,
  input  logic [HW-1:0] pkt_i,
  input  logic [HW-1:0] chunks_i,
  input  logic [NW-1:0] null_i,
  output logic          win_o,
  output logic          pix_o,
  output logic          nul_o
);
  localparam int SW = HW + 2;

  logic [SW-1:0] pkt_len, nul_len, slot, s_q, cur_s;
  logic [HW-1:0] n_chunks, c_q, cur_c;
  logic          busy_q, nul_on;

  assign nul_on   = !burst_i && (null_i != '0);
  assign pkt_len  = SW'(pkt_i) + SW'(HDR_BYTES);
  assign nul_len  = nul_on ? SW'(null_i) + SW'(HDR_BYTES) : '0;
  assign slot     = pkt_len + nul_len;
  assign n_chunks = (burst_i || chunks_i == '0) ? HW'(1) : chunks_i;

  assign cur_s = start_i ? '0 : s_q;
  assign cur_c = start_i ? '0 : c_q;
  assign win_o = start_i || busy_q;
  assign pix_o = win_o && (cur_s == '0);
  assign nul_o = win_o && nul_on && (cur_s == pkt_len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      s_q    <= '0;
      c_q    <= '0;
    end else if (clr_i || line_end_i) begin
      busy_q <= 1'b0;
      s_q    <= '0;
      c_q    <= '0;
    end else if (win_o) begin
      if (cur_s == slot - 1'b1) begin
        s_q    <= '0;
        c_q    <= cur_c + 1'b1;
        busy_q <= (cur_c != n_chunks - 1'b1);
      end else begin
        s_q    <= cur_s + 1'b1;
        c_q    <= cur_c;
        busy_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vt_vseq.sv
module vt_vseq
  import vt_pkg::*;
(
  input  vt_cfg_t       cfg_q_i,
  input  vt_cfg_t       cfg_live_i,
  input  logic [1:0]    vreg_i,
  input  logic [AW-1:0] vcnt_i,
  output logic [1:0]    nxt_reg_o,
  output logic [AW-1:0] nxt_cnt_o,
  output logic          nxt_frame_o,
  output logic [1:0]    start_reg_o
);
  logic [AW-1:0] cur_len;
  logic [2:0]    in_frame, fresh;
  logic          stay;

  assign cur_len     = reg_len(cfg_q_i, vreg_i);
  assign stay        = ((AW+1)'(vcnt_i) + 1'b1) < (AW+1)'(cur_len);
  assign in_frame    = first_region(cfg_q_i, {1'b0, vreg_i} + 3'd1);
  assign fresh       = first_region(cfg_live_i, 3'd0);
  assign start_reg_o = fresh[2] ? VR_SYNC : fresh[1:0];

  always_comb begin
    nxt_frame_o = 1'b0;
    nxt_cnt_o   = '0;
    nxt_reg_o   = start_reg_o;
    if (stay) begin
      nxt_reg_o = vreg_i;
      nxt_cnt_o = vcnt_i + 1'b1;
    end else if (!in_frame[2]) begin
      nxt_reg_o = in_frame[1:0];
    end else begin
      nxt_frame_o = 1'b1;
    end
  end
endmodule

// File: rtl/dsi_vid_timing.sv
module dsi_vid_timing
  import vt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [31:0]   hblk_i,
  input  logic [15:0]   line_time_i,
  input  logic [29:0]   vblk_i,
  input  logic [15:0]   vact_i,
  input  logic [13:0]   mode_cfg_i,
  input  logic [31:0]   pkt_cfg_i,
  input  logic [9:0]    null_size_i,
  output logic [1:0]    vregion_o,
  output logic          frame_start_o,
  output logic          sync_start_o,
  output logic          sync_end_o,
  output logic          pixel_pkt_o,
  output logic          null_pkt_o,
  output logic          blank_o,
  output logic          lp_allowed_o
);
  vt_cfg_t       cfg_live, cfg_q;
  logic          running_q, first_q;
  logic [1:0]    vreg_q;
  logic [AW-1:0] vcnt_q;
  logic [HW-1:0] hcnt;
  logic          line_end, hs, hb, act_pt, hsa_pt;
  logic          win, pix, nul, act_line, en_v, pulse;
  logic [1:0]    nxt_reg, start_reg;
  logic [AW-1:0] nxt_cnt;
  logic          nxt_frame;

  always_comb begin
    cfg_live        = '0;
    cfg_live.hsa    = hblk_i[31:16];
    cfg_live.hbp    = hblk_i[15:0];
    cfg_live.line   = line_time_i;
    cfg_live.vsa    = vblk_i[29:20];
    cfg_live.vbp    = vblk_i[19:10];
    cfg_live.vfp    = vblk_i[9:0];
    cfg_live.vact   = vact_i;
    cfg_live.mode   = mode_cfg_i[1:0];
    cfg_live.lp_en  = mode_cfg_i[13:8];
    cfg_live.pkt    = pkt_cfg_i[15:0];
    cfg_live.chunks = pkt_cfg_i[31:16];
    cfg_live.nul    = null_size_i;
  end

  vt_hline u_hline (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (!(run_i && running_q)),
    .adv_i      (running_q),
    .hsa_i      (cfg_q.hsa),
    .hbp_i      (cfg_q.hbp),
    .line_i     (cfg_q.line),
    .hcnt_o     (hcnt),
    .line_end_o (line_end),
    .hs_o       (hs),
    .hb_o       (hb),
    .act_pt_o   (act_pt),
    .hsa_pt_o   (hsa_pt)
  );

  assign act_line = running_q && (vreg_q == VR_ACT);

  vt_chunk u_chunk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (!(run_i && running_q)),
    .start_i    (act_line && act_pt),
    .line_end_i (line_end),
    .burst_i    (cfg_q.mode[1]),
    .pkt_i      (cfg_q.pkt),
    .chunks_i   (cfg_q.chunks),
    .null_i     (cfg_q.nul),
    .win_o      (win),
    .pix_o      (pix),
    .nul_o      (nul)
  );

  vt_vseq u_vseq (
    .cfg_q_i     (cfg_q),
    .cfg_live_i  (cfg_live),
    .vreg_i      (vreg_q),
    .vcnt_i      (vcnt_q),
    .nxt_reg_o   (nxt_reg),
    .nxt_cnt_o   (nxt_cnt),
    .nxt_frame_o (nxt_frame),
    .start_reg_o (start_reg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      first_q   <= 1'b0;
      vreg_q    <= VR_SYNC;
      vcnt_q    <= '0;
      cfg_q     <= '0;
    end else if (!run_i) begin
      running_q <= 1'b0;
      first_q   <= 1'b0;
      vreg_q    <= VR_SYNC;
      vcnt_q    <= '0;
    end else if (!running_q) begin
      running_q <= 1'b1;
      first_q   <= 1'b1;
      cfg_q     <= cfg_live;
      vreg_q    <= start_reg;
      vcnt_q    <= '0;
    end else if (line_end) begin
      first_q <= nxt_frame;
      vreg_q  <= nxt_reg;
      vcnt_q  <= nxt_cnt;
      if (nxt_frame) cfg_q <= cfg_live;
    end
  end

  always_comb begin
    case (vreg_q)
      VR_SYNC:  en_v = cfg_q.lp_en[0];
      VR_BACK:  en_v = cfg_q.lp_en[1];
      VR_ACT:   en_v = cfg_q.lp_en[3];
      default:  en_v = cfg_q.lp_en[2];
    endcase
  end

  assign pulse         = (cfg_q.mode != MODE_EVENTS);
  assign vregion_o     = vreg_q;
  assign sync_start_o  = running_q && (hcnt == '0);
  assign frame_start_o = sync_start_o && first_q;
  assign sync_end_o    = running_q && pulse && hsa_pt;
  assign pixel_pkt_o   = pix;
  assign null_pkt_o    = nul;
  assign blank_o       = running_q && !act_line && act_pt;
  assign lp_allowed_o  = running_q && !hs && !win &&
                         (act_line ? (cfg_q.lp_en[3] && (hb ? cfg_q.lp_en[4] : cfg_q.lp_en[5]))
                                   : en_v);
endmodule

// File: rtl/vt_chk.sv
module vt_chk
  import vt_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          run_i,
  input logic [1:0]    vregion_o,
  input logic          frame_start_o,
  input logic          sync_start_o,
  input logic          sync_end_o,
  input logic          pixel_pkt_o,
  input logic          null_pkt_o,
  input logic          blank_o,
  input logic          lp_allowed_o,
  input logic          running_i,
  input logic [HW-1:0] hcnt_i,
  input vt_cfg_t       cfg_i
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !(frame_start_o || sync_start_o || sync_end_o || pixel_pkt_o ||
                 null_pkt_o || blank_o || lp_allowed_o)); // R1

  AST_FRAME_ON_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> sync_start_o); // R2

  AST_HCNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_i |-> (cfg_i.line == '0 ? hcnt_i == '0 : hcnt_i < cfg_i.line)); // R2

  AST_EVENT_NO_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.mode == MODE_EVENTS) |-> !sync_end_o); // R4

  AST_PKT_IN_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pixel_pkt_o || null_pkt_o) |-> (vregion_o == VR_ACT)); // R5

  AST_PKT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pixel_pkt_o, null_pkt_o, blank_o})); // R5

  AST_BURST_NO_NULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i.mode[1] |-> !null_pkt_o); // R7

  AST_BLANK_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_o |-> (vregion_o != VR_ACT)); // R8

  AST_NO_LP_IN_HSYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_i && hcnt_i < cfg_i.hsa) |-> !lp_allowed_o); // R9

  AST_NO_LP_ON_PKT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pixel_pkt_o || null_pkt_o) |-> !lp_allowed_o); // R9

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_i && $past(running_i) && !frame_start_o) |-> $stable(cfg_i)); // R11
endmodule

bind dsi_vid_timing vt_chk i_vt_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .run_i         (run_i),
  .vregion_o     (vregion_o),
  .frame_start_o (frame_start_o),
  .sync_start_o  (sync_start_o),
  .sync_end_o    (sync_end_o),
  .pixel_pkt_o   (pixel_pkt_o),
  .null_pkt_o    (null_pkt_o),
  .blank_o       (blank_o),
  .lp_allowed_o  (lp_allowed_o),
  .running_i     (running_q),
  .hcnt_i        (hcnt),
  .cfg_i         (cfg_q)
);

// File: tb/test_dsi_vid_timing.sv
module test_dsi_vid_timing;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic [31:0] hblk_i = '0;
  logic [15:0] line_time_i = '0;
  logic [29:0] vblk_i = '0;
  logic [15:0] vact_i = '0;
  logic [13:0] mode_cfg_i = '0;
  logic [31:0] pkt_cfg_i = '0;
  logic [9:0]  null_size_i = '0;
  logic [1:0]  vregion_o;
  logic        frame_start_o, sync_start_o, sync_end_o, pixel_pkt_o;
  logic        null_pkt_o, blank_o, lp_allowed_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    int hsa, hbp, line, vsa, vbp, vact, vfp, mode, lp, pkt, chunks, nul;
  } cfg_t;

  always #5 clk = ~clk;

  dsi_vid_timing i_dsi_vid_timing (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run_i), .hblk_i(hblk_i),
    .line_time_i(line_time_i), .vblk_i(vblk_i), .vact_i(vact_i),
    .mode_cfg_i(mode_cfg_i), .pkt_cfg_i(pkt_cfg_i), .null_size_i(null_size_i),
    .vregion_o(vregion_o), .frame_start_o(frame_start_o), .sync_start_o(sync_start_o),
    .sync_end_o(sync_end_o), .pixel_pkt_o(pixel_pkt_o), .null_pkt_o(null_pkt_o),
    .blank_o(blank_o), .lp_allowed_o(lp_allowed_o)
  );

  function automatic logic [8:0] observed();
    return {vregion_o, frame_start_o, sync_start_o, sync_end_o,
            pixel_pkt_o, null_pkt_o, blank_o, lp_allowed_o};
  endfunction

  function automatic int frame_lines(cfg_t c);
    int t;
    t = c.vsa + c.vbp + c.vact + c.vfp;
    return (t == 0) ? 1 : t;
  endfunction

  function automatic int line_len(cfg_t c);
    return (c.line == 0) ? 1 : c.line;
  endfunction

  // expected {vregion, frame, sync, sync_end, pix, null, blank, lp}
  function automatic logic [8:0] exp_at(cfg_t c, int li, int h);
    int lens[4];
    int rg, acc, st, pl, nl, slot, n;
    bit act, pulse, burst, win, pix, nu, blk, hs, hb, env, lpv;
    lens[0] = c.vsa; lens[1] = c.vbp; lens[2] = c.vact; lens[3] = c.vfp;
    rg = 0; acc = 0;
    for (int i = 0; i < 4; i++) begin
      if (li >= acc && li < acc + lens[i]) rg = i;
      acc += lens[i];
    end
    act   = (rg == 2);
    st    = c.hsa + c.hbp;
    pulse = (c.mode != 1);
    burst = (c.mode >= 2);
    pl    = c.pkt + 6;
    nl    = (!burst && c.nul > 0) ? c.nul + 6 : 0;
    slot  = pl + nl;
    n     = burst ? 1 : ((c.chunks == 0) ? 1 : c.chunks);
    win   = act && h >= st && h < st + n * slot;
    pix   = win && ((h - st) % slot == 0);
    nu    = win && nl > 0 && ((h - st) % slot == pl);
    blk   = !act && h == st;
    hs    = h < c.hsa;
    hb    = !hs && h < st;
    case (rg)
      0: env = c.lp[0];
      1: env = c.lp[1];
      2: env = c.lp[3];
      default: env = c.lp[2];
    endcase
    lpv = !hs && !win && (act ? (c.lp[3] && (hb ? c.lp[4] : c.lp[5])) : env);
    return {2'(rg), li == 0 && h == 0, h == 0, pulse && h == c.hsa, pix, nu, blk, lpv};
  endfunction

  task automatic apply(cfg_t c);
    hblk_i      = {16'(c.hsa), 16'(c.hbp)};
    line_time_i = 16'(c.line);
    vblk_i      = {10'(c.vsa), 10'(c.vbp), 10'(c.vfp)};
    vact_i      = 16'(c.vact);
    mode_cfg_i  = {6'(c.lp), 6'b0, 2'(c.mode)};
    pkt_cfg_i   = {16'(c.chunks), 16'(c.pkt)};
    null_size_i = 10'(c.nul);
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // run nf frames; frame 0 uses a, later frames b (b applied at frame0 line chg)
  task automatic run_case(string tag, cfg_t a, cfg_t b, int nf, int chg);
    int bad;
    logic [8:0] g, e, fg, fe;
    cfg_t c;
    bad = 0; fg = '0; fe = '0;
    apply(a);
    @(negedge clk); run_i = 1'b1;
    for (int f = 0; f < nf; f++) begin
      c = (f == 0) ? a : b;
      for (int li = 0; li < frame_lines(c); li++)
        for (int h = 0; h < line_len(c); h++) begin
          @(negedge clk);
          g = observed();
          e = exp_at(c, li, h);
          if (g !== e) begin
            if (bad == 0) begin
              fg = g; fe = e;
              $display("  mismatch %s at frame %0d line %0d offset %0d", tag, f, li, h);
            end
            bad++;
          end
          if (f == 0 && li == chg && h == 0) apply(b);
        end
    end
    chk(bad == 0, tag, 32'(fg), 32'(fe));
    run_i = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(observed() == 9'd0, {"R1 idle after ", tag}, 32'(observed()), 32'd0);
  endtask

  function automatic cfg_t rand_cfg();
    cfg_t c;
    int n, slot;
    c.hsa    = 1 + int'($urandom % 5);
    c.hbp    = int'($urandom % 6);
    c.pkt    = 1 + int'($urandom % 8);
    c.nul    = int'($urandom % 5);
    c.chunks = int'($urandom % 4);
    c.mode   = int'($urandom % 4);
    c.lp     = int'($urandom % 64);
    c.vsa    = int'($urandom % 3);
    c.vbp    = int'($urandom % 3);
    c.vact   = 1 + int'($urandom % 3);
    c.vfp    = int'($urandom % 3);
    n    = (c.mode >= 2 || c.chunks == 0) ? 1 : c.chunks;
    slot = c.pkt + 6 + ((c.mode < 2 && c.nul > 0) ? c.nul + 6 : 0);
    c.line = c.hsa + c.hbp + n * slot + int'($urandom % 8);
    return c;
  endfunction

  function automatic cfg_t base_cfg();
    cfg_t c;
    c.hsa = 3; c.hbp = 2; c.pkt = 4; c.nul = 2; c.chunks = 3; c.mode = 0;
    c.lp = 6'h3f; c.vsa = 1; c.vbp = 1; c.vact = 2; c.vfp = 1;
    c.line = 3 + 2 + 3 * (10 + 8) + 4;
    return c;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cfg_t c, d;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    chk(observed() == 9'd0, "R1 reset state", 32'(observed()), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(observed() == 9'd0, "R1 idle after reset", 32'(observed()), 32'd0);

    c = base_cfg();
    run_case("R6 nonburst chunks with nulls", c, c, 2, -1);

    c = base_cfg(); c.mode = 1;
    run_case("R4 sync events no end", c, c, 1, -1);

    c = base_cfg(); c.mode = 2; c.chunks = 3; c.nul = 5;
    run_case("R7 burst ignores chunk and null", c, c, 1, -1);
    c.mode = 3;
    run_case("R7 mode 3 burst", c, c, 1, -1);

    c = base_cfg(); c.vsa = 0; c.vbp = 0; c.vfp = 0; c.vact = 2;
    run_case("R3 zero regions skipped", c, c, 2, -1);
    c.vact = 0;
    run_case("R3 all zero single sync line", c, c, 3, -1);

    c = base_cfg(); c.line = 20;
    run_case("R10 window cut at line end", c, c, 2, -1);

    c = base_cfg(); c.lp = 6'b010101;
    run_case("R9 lp enables mixed", c, c, 1, -1);
    c.lp = 6'b111000;
    run_case("R9 lp enables active only", c, c, 1, -1);

    c = base_cfg(); c.vact = 1; c.vsa = 2; c.vfp = 2;
    run_case("R8 blanking lines", c, c, 1, -1);

    c = base_cfg(); c.line = 0; c.vsa = 1; c.vbp = 0; c.vact = 0; c.vfp = 1;
    run_case("R2 zero line time", c, c, 2, -1);

    c = base_cfg();
    d = base_cfg(); d.line = 40; d.chunks = 1; d.nul = 0; d.vsa = 2; d.hsa = 5;
    run_case("R11 mid-frame change deferred", c, d, 2, 2);

    for (int k = 0; k < 25; k++) begin
      c = rand_cfg();
      run_case("R2 R3 R5 random frame", c, c, 2, -1);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule